// File: doc/BRIEF.md
# Processor Bus Address Decoder with Write Protection

This block sits on a processor bus and classifies each access by address into one of three regions: boot ROM starting at address zero, main RAM starting at 0x02000000, and a 256-byte window of control registers at 0x01F80000. An access that lands nowhere asserts a memory-exception trap in the same cycle as the strobe. The ROM and RAM regions that are recognised are not fixed. Software sets them through two size fields of a memory-configuration register. Out of reset they are small: 4 KB of ROM and 256 KB of RAM.

The register window also holds a control register, a wait-state configuration register and two RAM limit registers. When bit 3 of the control register is set, RAM writes outside the address window formed by the two limit registers trap instead of reaching RAM. The wait-state fields are driven out continuously for the memory controller to use. Any other word in the window is plain storage. It reads back what was written and never traps.

Every access completes in the cycle its strobe is high, so there is no handshake and no back-pressure. Selects, trap and read data are combinational from the address and strobes. Register writes take effect at the clock edge that ends the access cycle.

Top module: `addr_decoder_top`

## Requirements
- R1: After reset all window registers read 0, ROM decodes 0x00000000–0x00000FFF and RAM decodes 0x02000000–0x0203FFFF, and both wait-state outputs are 0.
- R2: The ROM size field is bits [2:0] of the memory-configuration register at window offset 0x10. The ROM region spans 4 KB << field, which gives at most 512 KB.
- R3: The RAM size field is bits [10:8] of the same register. The RAM region spans 256 KB << min(field, 4), so field values of 4 and above give 4 MB.
- R4: All other bits of the memory-configuration register are stored and read back but do not change decoding.
- R5: A read or write outside the decoded ROM, decoded RAM and register window asserts mem_trap during that strobe and asserts no select. With no strobe, no select and no trap are asserted.
- R6: Addresses 0x01F80000–0x01F800FF assert reg_sel and never trap. The word index is addr[7:2]. A word at an offset with no assigned function stores its write data and reads it back.
- R7: The control register at offset 0x00 keeps only bits 0, 1 and 3, and its other bits read 0. Bit 3 enables write protection.
- R8: With protection enabled, a RAM write with address < limit-low (offset 0x20) or address >= limit-high (offset 0x24) asserts mem_trap and not ram_sel. RAM reads and ROM writes are unaffected.
- R9: With protection disabled, every write within the decoded RAM asserts ram_sel without trapping.
- R10: The wait-state register at offset 0x18 drives ws_rom from bits [3:0] and ws_ram from bits [7:4], starting the cycle after it is written.
- R11: reg_rdata is 0 except during a read strobe to the register window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| rom_sel | output | 1 | Access selects ROM |
| ram_sel | output | 1 | Access selects RAM |
| reg_sel | output | 1 | Access selects the register window |
| mem_trap | output | 1 | Memory-exception trap, high during the faulting strobe |
| reg_rdata | output | 32 | Register window read data |
| ws_rom | output | 4 | ROM wait-state count |
| ws_ram | output | 4 | RAM wait-state count |

## Verification
Region boundaries are probed with the last word inside and the first word outside each region, at the reset sizes and at several programmed sizes, including a RAM field above the clamp point. This separates an off-by-one limit, a wrong field position and a missing clamp. Protection is tried with writes just below, at, and just past both limit registers, and also with reads and ROM writes. This separates an inclusive comparison from an exclusive one and shows whether the check is wrongly applied to reads or other regions. Register-window patterns write all-ones and scattered values to assigned and unassigned offsets. This shows masking in the control register, plain storage elsewhere, and that the extra configuration bits do not affect decoding.

// File: rtl/adec_pkg.sv
package adec_pkg;
  typedef enum logic [1:0] {RG_NONE, RG_ROM, RG_RAM, RG_REGS} region_e;

  // word indices inside the register window
  localparam int IDX_CTRL = 0;
  localparam int IDX_MCFG = 4;
  localparam int IDX_WAIT = 6;
  localparam int IDX_LIMLO = 8;
  localparam int IDX_LIMHI = 9;

  localparam int CTRL_PROT_BIT = 3;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_000B;
endpackage

// File: rtl/adec_size_calc.sv
module adec_size_calc #(
  parameter int ADDR_W   = 32,
  parameter int FIELD_W  = 3,
  parameter int MIN_LOG2 = 12,
  parameter int MAX_LOG2 = 19
) (
  input  logic [FIELD_W-1:0] field,
  output logic [ADDR_W-1:0]  limit
);
  localparam int SPAN = MAX_LOG2 - MIN_LOG2;

  logic [FIELD_W-1:0] shift;

  always_comb begin
    if (int'(field) > SPAN) shift = FIELD_W'(SPAN);
    else                    shift = field;
    limit = ADDR_W'(1) << (MIN_LOG2 + int'(shift));
  end
endmodule

// File: rtl/adec_region_map.sv
module adec_region_map
  import adec_pkg::*;
#(
  parameter int               ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] RAM_BASE    = 32'h0200_0000,
  parameter logic [ADDR_W-1:0] REG_BASE    = 32'h01F8_0000,
  parameter int               REG_WIN_LOG2 = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] rom_limit,
  input  logic [ADDR_W-1:0] ram_limit,
  output region_e           region
);
  logic [ADDR_W-1:0] ram_off;
  logic in_rom, in_ram, in_regs;

  always_comb begin
    ram_off = addr - RAM_BASE;
    in_rom  = addr < rom_limit;
    in_ram  = (addr >= RAM_BASE) && (ram_off < ram_limit);
    in_regs = addr[ADDR_W-1:REG_WIN_LOG2] == REG_BASE[ADDR_W-1:REG_WIN_LOG2];
    if (in_rom)       region = RG_ROM;
    else if (in_ram)  region = RG_RAM;
    else if (in_regs) region = RG_REGS;
    else              region = RG_NONE;
  end
endmodule

// File: rtl/adec_protect.sv
module adec_protect #(
  parameter int ADDR_W = 32
) (
  input  logic              enable,
  input  logic              is_write,
  input  logic              is_ram,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lim_lo,
  input  logic [ADDR_W-1:0] lim_hi,
  output logic              violation
);
  logic outside;

  always_comb begin
    outside   = (addr < lim_lo) || (addr >= lim_hi);
    violation = enable && is_write && is_ram && outside;
  end
endmodule

// File: rtl/adec_regfile.sv
module adec_regfile
  import adec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WORDS    = 64,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] mcfg,
  output logic [DATA_W-1:0] wait_cfg,
  output logic [DATA_W-1:0] lim_lo,
  output logic [DATA_W-1:0] lim_hi
);
  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [DATA_W-1:0] KEEP = (i == IDX_CTRL) ? DATA_W'(CTRL_KEEP) : '1;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[i] <= '0;
      else if (we && (idx == IDX_W'(i)))
        word_q[i] <= wdata & KEEP;
    end
  end

  assign rdata    = word_q[idx];
  assign ctrl     = word_q[IDX_CTRL];
  assign mcfg     = word_q[IDX_MCFG];
  assign wait_cfg = word_q[IDX_WAIT];
  assign lim_lo   = word_q[IDX_LIMLO];
  assign lim_hi   = word_q[IDX_LIMHI];
endmodule

// File: rtl/addr_decoder_top.sv
module addr_decoder_top
  import adec_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int ROM_MIN_LOG2 = 12,
  parameter int ROM_MAX_LOG2 = 19,
  parameter int RAM_MIN_LOG2 = 18,
  parameter int RAM_MAX_LOG2 = 22,
  parameter int SIZE_W       = 3,
  parameter int ROM_SIZE_LSB = 0,
  parameter int RAM_SIZE_LSB = 8,
  parameter int WS_W         = 4,
  parameter int REG_WIN_LOG2 = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h0200_0000,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'h01F8_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              reg_sel,
  output logic              mem_trap,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [WS_W-1:0]   ws_rom,
  output logic [WS_W-1:0]   ws_ram
);
  localparam int WORDS = 1 << (REG_WIN_LOG2 - 2);
  localparam int IDX_W = REG_WIN_LOG2 - 2;

  logic [ADDR_W-1:0] rom_limit, ram_limit;
  logic [DATA_W-1:0] rf_rdata, ctrl, mcfg, wait_cfg, lim_lo, lim_hi;
  region_e           region;
  logic              access, violation, rf_we;

  adec_size_calc #(.ADDR_W(ADDR_W), .FIELD_W(SIZE_W),
                   .MIN_LOG2(ROM_MIN_LOG2), .MAX_LOG2(ROM_MAX_LOG2)) u_rom_size (
    .field (mcfg[ROM_SIZE_LSB +: SIZE_W]),
    .limit (rom_limit)
  );

  adec_size_calc #(.ADDR_W(ADDR_W), .FIELD_W(SIZE_W),
                   .MIN_LOG2(RAM_MIN_LOG2), .MAX_LOG2(RAM_MAX_LOG2)) u_ram_size (
    .field (mcfg[RAM_SIZE_LSB +: SIZE_W]),
    .limit (ram_limit)
  );

  adec_region_map #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .REG_BASE(REG_BASE),
                    .REG_WIN_LOG2(REG_WIN_LOG2)) u_map (
    .addr      (bus_addr),
    .rom_limit (rom_limit),
    .ram_limit (ram_limit),
    .region    (region)
  );

  adec_protect #(.ADDR_W(ADDR_W)) u_prot (
    .enable    (ctrl[CTRL_PROT_BIT]),
    .is_write  (bus_wr),
    .is_ram    (region == RG_RAM),
    .addr      (bus_addr),
    .lim_lo    (lim_lo),
    .lim_hi    (lim_hi),
    .violation (violation)
  );

  assign rf_we = bus_wr && (region == RG_REGS);

  adec_regfile #(.DATA_W(DATA_W), .WORDS(WORDS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (rf_we),
    .idx      (bus_addr[REG_WIN_LOG2-1:2]),
    .wdata    (bus_wdata),
    .rdata    (rf_rdata),
    .ctrl     (ctrl),
    .mcfg     (mcfg),
    .wait_cfg (wait_cfg),
    .lim_lo   (lim_lo),
    .lim_hi   (lim_hi)
  );

  always_comb begin
    access    = bus_rd || bus_wr;
    rom_sel   = access && (region == RG_ROM);
    ram_sel   = access && (region == RG_RAM) && !violation;
    reg_sel   = access && (region == RG_REGS);
    mem_trap  = access && ((region == RG_NONE) || violation);
    reg_rdata = (bus_rd && region == RG_REGS) ? rf_rdata : '0;
  end

  assign ws_rom = wait_cfg[WS_W-1:0];
  assign ws_ram = wait_cfg[2*WS_W-1:WS_W];

  // R5: at most one outcome per access
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel, reg_sel, mem_trap}));

  // R5: idle bus stays quiet
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> !(rom_sel || ram_sel || reg_sel || mem_trap));

  // R2: ROM never selected beyond its largest size
  a_r2_rom_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (bus_addr < (ADDR_W'(1) << ROM_MAX_LOG2)));

  // R3: RAM never selected beyond its largest size
  a_r3_ram_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (bus_addr >= RAM_BASE &&
                 (bus_addr - RAM_BASE) < (ADDR_W'(1) << RAM_MAX_LOG2)));

  // R8: a protected RAM write that is selected lies within the limits
  a_r8_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel && bus_wr && ctrl[CTRL_PROT_BIT]) |-> (bus_addr >= lim_lo && bus_addr < lim_hi));

  // R11: read data is quiet outside register reads
  a_r11_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && reg_sel) |-> (reg_rdata == '0));
endmodule

// File: tb/tb_addr_decoder_top.sv
module tb_addr_decoder_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        rom_sel, ram_sel, reg_sel, mem_trap;
  logic [31:0] reg_rdata;
  logic [3:0]  ws_rom, ws_ram;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [31:0] WIN = 32'h01F8_0000;
  // outcome codes {rom, ram, reg, trap}
  localparam logic [3:0] O_ROM = 4'b1000, O_RAM = 4'b0100, O_REG = 4'b0010,
                         O_TRAP = 4'b0001, O_NONE = 4'b0000;

  always #10 clk = ~clk;  // 50 MHz

  addr_decoder_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rom_sel(rom_sel), .ram_sel(ram_sel), .reg_sel(reg_sel),
    .mem_trap(mem_trap), .reg_rdata(reg_rdata), .ws_rom(ws_rom), .ws_ram(ws_ram)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access cycle: drive at negedge, sample mid-cycle, commit at posedge
  task automatic access(input logic rd, input logic wr, input logic [31:0] a,
                        input logic [31:0] d, output logic [3:0] outc,
                        output logic [31:0] rdat);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #2;
    outc = {rom_sel, ram_sel, reg_sel, mem_trap};
    rdat = reg_rdata;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic probe(input string req, input logic rd, input logic wr,
                       input logic [31:0] a, input logic [3:0] exp);
    logic [3:0] o; logic [31:0] r;
    access(rd, wr, a, 32'h5A5A_5A5A, o, r);
    chk(req, {28'd0, o}, {28'd0, exp});
  endtask

  task automatic wreg(input logic [7:0] off, input logic [31:0] d);
    logic [3:0] o; logic [31:0] r;
    access(1'b0, 1'b1, WIN | 32'(off), d, o, r);
  endtask

  task automatic rreg(input string req, input logic [7:0] off, input logic [31:0] exp);
    logic [3:0] o; logic [31:0] r;
    access(1'b1, 1'b0, WIN | 32'(off), '0, o, r);
    chk(req, r, exp);
    chk(req, {28'd0, o}, {28'd0, O_REG});
  endtask

  task automatic t_reset;
    rreg("R1 ctrl after reset", 8'h00, 32'h0);
    rreg("R1 mcfg after reset", 8'h10, 32'h0);
    chk("R1 ws_rom after reset", {28'd0, ws_rom}, 32'h0);
    chk("R1 ws_ram after reset", {28'd0, ws_ram}, 32'h0);
    probe("R1 last ROM word", 1, 0, 32'h0000_0FFC, O_ROM);
    probe("R1 past ROM", 1, 0, 32'h0000_1000, O_TRAP);
    probe("R1 last RAM word", 1, 0, 32'h0203_FFFC, O_RAM);
    probe("R1 past RAM", 1, 0, 32'h0204_0000, O_TRAP);
  endtask

  task automatic t_rom_size;
    wreg(8'h10, 32'h0000_0003);
    probe("R2 32K ROM last", 1, 0, 32'h0000_7FFC, O_ROM);
    probe("R2 32K ROM past", 1, 0, 32'h0000_8000, O_TRAP);
    wreg(8'h10, 32'h0000_0007);
    probe("R2 512K ROM last", 1, 0, 32'h0007_FFFC, O_ROM);
    probe("R2 512K ROM past", 1, 0, 32'h0008_0000, O_TRAP);
  endtask

  task automatic t_ram_size;
    wreg(8'h10, 32'h0000_0200);
    probe("R3 1M RAM last", 1, 0, 32'h020F_FFFC, O_RAM);
    probe("R3 1M RAM past", 1, 0, 32'h0210_0000, O_TRAP);
    probe("R3 ROM back to 4K", 1, 0, 32'h0000_1000, O_TRAP);
    wreg(8'h10, 32'h0000_0700);
    probe("R3 clamp RAM last", 1, 0, 32'h023F_FFFC, O_RAM);
    probe("R3 clamp RAM past", 1, 0, 32'h0240_0000, O_TRAP);
  endtask

  task automatic t_other_bits;
    wreg(8'h10, 32'hFFFF_F8F8);
    rreg("R4 mcfg readback", 8'h10, 32'hFFFF_F8F8);
    probe("R4 ROM stays 4K", 1, 0, 32'h0000_1000, O_TRAP);
    probe("R4 RAM stays 256K", 1, 0, 32'h0204_0000, O_TRAP);
  endtask

  task automatic t_unmapped;
    probe("R5 above window", 1, 0, 32'h01F8_0100, O_TRAP);
    probe("R5 hole write", 0, 1, 32'h0100_0000, O_TRAP);
    probe("R5 top of space", 1, 0, 32'hFFFF_FFFC, O_TRAP);
    probe("R5 no strobe", 0, 0, 32'hFFFF_FFFC, O_NONE);
  endtask

  task automatic t_scratch;
    logic [3:0] o; logic [31:0] r;
    access(1'b0, 1'b1, WIN | 32'h0FC, 32'hDEAD_BEEF, o, r);
    chk("R6 scratch write no trap", {28'd0, o}, {28'd0, O_REG});
    wreg(8'h44, 32'h1234_5678);
    rreg("R6 scratch 0xFC", 8'hFC, 32'hDEAD_BEEF);
    rreg("R6 scratch 0x44", 8'h44, 32'h1234_5678);
    chk("R6 no side effect on ws", {24'd0, ws_ram, ws_rom}, 32'h0);
  endtask

  task automatic t_ctrl;
    wreg(8'h00, 32'hFFFF_FFFF);
    rreg("R7 ctrl mask", 8'h00, 32'h0000_000B);
    wreg(8'h00, 32'h0000_0000);
  endtask

  task automatic t_protect;
    wreg(8'h10, 32'h0000_0400);
    wreg(8'h20, 32'h0210_0000);
    wreg(8'h24, 32'h0220_0000);
    wreg(8'h00, 32'h0000_0008);
    probe("R8 below low", 0, 1, 32'h020F_FFFC, O_TRAP);
    probe("R8 at low", 0, 1, 32'h0210_0000, O_RAM);
    probe("R8 last inside", 0, 1, 32'h021F_FFFC, O_RAM);
    probe("R8 at high", 0, 1, 32'h0220_0000, O_TRAP);
    probe("R8 read outside ok", 1, 0, 32'h0200_0000, O_RAM);
    probe("R8 ROM write ok", 0, 1, 32'h0000_0000, O_ROM);
    wreg(8'h00, 32'h0000_0000);
    probe("R9 disabled write", 0, 1, 32'h0200_0000, O_RAM);
    probe("R9 disabled write high", 0, 1, 32'h023F_FFFC, O_RAM);
  endtask

  task automatic t_wait;
    wreg(8'h18, 32'h0000_00A5);
    chk("R10 ws_rom", {28'd0, ws_rom}, 32'h5);
    chk("R10 ws_ram", {28'd0, ws_ram}, 32'hA);
    rreg("R10 wait readback", 8'h18, 32'h0000_00A5);
  endtask

  task automatic t_rdata;
    logic [3:0] o; logic [31:0] r;
    access(1'b1, 1'b0, 32'h0000_0000, '0, o, r);
    chk("R11 ROM read rdata", r, 32'h0);
    access(1'b0, 1'b1, WIN | 32'h018, 32'h0000_00A5, o, r);
    chk("R11 reg write rdata", r, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_rom_size();
    t_ram_size();
    t_other_bits();
    t_unmapped();
    t_scratch();
    t_ctrl();
    t_protect();
    t_wait();
    t_rdata();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule